// File: doc/BRIEF.md
# SPI NOR Command Sequencer

This block turns byte-wide register writes into serial NOR flash transactions on a single-bit SPI bus. Software first loads the setup values: the 24-bit target address, the data byte, a bit count and up to six free-form command bytes. It then writes the command register. Each trigger bit in that value asks for one bus operation:

- a status read, which sends the read-status opcode and captures the returned byte;
- a free-form programmed frame, whose content is set by the command bytes and the bit count;
- a single-byte program, which sends the program opcode, the address and the data byte.

Software learns that an operation has finished by polling the command register. A trigger bit stays set while its operation runs and clears itself when the operation ends. If auto-increment is requested with a byte program, the stored address moves forward by one after that program completes, so a run of byte writes needs only one address load. The block generates SPI mode 0 timing from the system clock. A single shift engine carries every frame.

Top module: `nor_cmd_seq`

Register offsets on `reg_addr`:

| Offset | Register |
|---|---|
| 0x0 | command |
| 0x1 | bit count |
| 0x2 | status result (read-only) |
| 0x3, 0x4, 0x5 | address low, middle, high byte |
| 0x6 | write data |
| 0x7 | enable key |
| 0x8 to 0xD | command bytes 0 to 5 |

## Requirements
- R1: The command register bit positions are: bit1 status read, bit2 programmed frame, bit4 byte program, bit7 auto-increment. Bits 0, 3, 5 and 6 always read back as 0 and start no bus activity.
- R2: A write to the command register is ignored unless the enable key register (offset 0x7) holds 0x30.
- R3: Each trigger bit clears itself when its frame ends. Bit7 keeps the value last written until the next accepted command write. An operation is complete when the command value ANDed with 0x7F reads 0.
- R4: A programmed frame shifts out the top N bits of the concatenation byte5..byte0, most significant bit first, where N is the bit count register. A count above 48 is treated as 48. A count of 0 finishes the operation without asserting chip select.
- R5: A status read is one frame of 16 clocks. The block sends 0x05, then captures 8 bits from MISO, MSB first. The captured byte is readable at offset 0x2.
- R6: A byte program is one 40-bit frame. The block sends 0x02, then address high, middle and low, then the write data byte. Without bit7 the stored address is left unchanged.
- R7: When bit7 accompanies a byte program, the 24-bit address increments by one after that frame, wrapping from 0xFFFFFF to 0.
- R8: The SPI bus uses mode 0:
  - SCLK is low whenever chip select is high.
  - Each SCLK period, taken from one rising edge to the next, is CLK_DIV system clocks.
  - Chip select stays high for at least CLK_DIV clocks between frames.
- R9: A command write that arrives while any trigger bit is set is ignored.
- R10: When several trigger bits are written together, the operations run as separate frames in this order: status read, then programmed frame, then byte program.
- R11: The bit count, address, write data, key and command-byte registers read back the value last written. Offsets 0xE and 0xF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Status reads are run against random status bytes from a bench flash model. This shows the sampling edge and the bit order of the returned byte, and separates them from the fixed opcode bits. Programmed frames use random command bytes and random counts from 1 to 48, together with the 8-bit and 32-bit cases and the 0 and over-range counts. These reveal an off-by-one in the count or a wrong byte order. Byte programs use random addresses and data, with and without auto-increment, plus the 0xFFFFFF wrap. Combined triggers, commands written while busy and commands written before the key is loaded show that ordering and gating are handled apart from the frame content.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   localparam int REG_AW = 4;
   localparam logic [REG_AW-1:0] OFF_CMD  = 4'h0;
   localparam logic [REG_AW-1:0] OFF_CNT  = 4'h1;
   localparam logic [REG_AW-1:0] OFF_STAT = 4'h2;
   localparam logic [REG_AW-1:0] OFF_ALO  = 4'h3;
   localparam logic [REG_AW-1:0] OFF_AMID = 4'h4;
   localparam logic [REG_AW-1:0] OFF_AHI  = 4'h5;
   localparam logic [REG_AW-1:0] OFF_WDAT = 4'h6;
   localparam logic [REG_AW-1:0] OFF_KEY  = 4'h7;
   localparam int PGM_BASE = 8;

   localparam logic [7:0] KEY_VALUE  = 8'h30;
   localparam logic [7:0] TRIG_MASK  = 8'h16;
   localparam logic [7:0] KEEP_MASK  = 8'h96;
   localparam int BIT_STAT = 1;
   localparam int BIT_PGM  = 2;
   localparam int BIT_WR   = 4;
   localparam int BIT_INC  = 7;

   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_PROG = 8'h02;

   typedef enum logic [1:0] {OP_NONE, OP_STAT, OP_PGM, OP_WR} op_e;
   typedef enum logic [2:0] {
      ENG_IDLE, ENG_LEAD, ENG_HI, ENG_LO, ENG_TAIL, ENG_GAP
   } eng_st_e;
endpackage

// File: rtl/nor_reg_file.sv
module nor_reg_file
   import nor_cmd_pkg::*;
#(
   parameter int PGM_BYTES = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REG_AW-1:0]      acc_addr,
   input  logic [7:0]             wr_data,
   input  logic [7:0]             cmd_val,
   input  logic                   stat_load,
   input  logic [7:0]             stat_data,
   input  logic                   addr_inc,
   output logic [7:0]             rd_data,
   output logic [23:0]            addr_q,
   output logic [7:0]             wdat_q,
   output logic [7:0]             cnt_q,
   output logic                   key_ok,
   output logic [8*PGM_BYTES-1:0] pgm_flat
);
   logic [7:0] stat_q;
   logic [7:0] key_q;
   logic [PGM_BYTES-1:0][7:0] pgm_q;
   logic addr_wr;

   assign addr_wr = wr_en && (acc_addr == OFF_ALO || acc_addr == OFF_AMID ||
                              acc_addr == OFF_AHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wdat_q <= '0;
         key_q  <= '0;
         stat_q <= '0;
         addr_q <= '0;
         pgm_q  <= '0;
      end else begin
         if (wr_en && acc_addr == OFF_CNT)  cnt_q  <= wr_data;
         if (wr_en && acc_addr == OFF_WDAT) wdat_q <= wr_data;
         if (wr_en && acc_addr == OFF_KEY)  key_q  <= wr_data;
         if (stat_load) stat_q <= stat_data;
         if (addr_wr) begin
            if (acc_addr == OFF_ALO)  addr_q[7:0]   <= wr_data;
            if (acc_addr == OFF_AMID) addr_q[15:8]  <= wr_data;
            if (acc_addr == OFF_AHI)  addr_q[23:16] <= wr_data;
         end else if (addr_inc) begin
            addr_q <= addr_q + 24'd1;
         end
         for (int i = 0; i < PGM_BYTES; i++) begin
            if (wr_en && acc_addr == REG_AW'(PGM_BASE + i)) pgm_q[i] <= wr_data;
         end
      end
   end

   assign key_ok   = (key_q == KEY_VALUE);
   assign pgm_flat = pgm_q;

   always_comb begin
      rd_data = '0;
      case (acc_addr)
         OFF_CMD:  rd_data = cmd_val;
         OFF_CNT:  rd_data = cnt_q;
         OFF_STAT: rd_data = stat_q;
         OFF_ALO:  rd_data = addr_q[7:0];
         OFF_AMID: rd_data = addr_q[15:8];
         OFF_AHI:  rd_data = addr_q[23:16];
         OFF_WDAT: rd_data = wdat_q;
         OFF_KEY:  rd_data = key_q;
         default: begin
            for (int i = 0; i < PGM_BYTES; i++) begin
               if (acc_addr == REG_AW'(PGM_BASE + i)) rd_data = pgm_q[i];
            end
         end
      endcase
   end

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_inc && !addr_wr) |=> $stable(addr_q));
endmodule

// File: rtl/nor_frame_builder.sv
module nor_frame_builder
   import nor_cmd_pkg::*;
#(
   parameter int PGM_BYTES = 6,
   parameter int FB        = 8 * PGM_BYTES,
   parameter int CNT_W     = $clog2(FB + 1)
) (
   input  op_e                    op,
   input  logic [23:0]            addr,
   input  logic [7:0]             wdat,
   input  logic [7:0]             cnt,
   input  logic [8*PGM_BYTES-1:0] pgm_flat,
   output logic [FB-1:0]          frame,
   output logic [CNT_W-1:0]       nbits
);
   logic [FB-1:0] stat_frame;
   logic [FB-1:0] wr_frame;
   logic [FB-1:0] pgm_frame;
   logic [CNT_W-1:0] pgm_bits;

   assign stat_frame = {OPC_RDSR, {(FB-8){1'b0}}};

   generate
      if (FB == 40) begin : g_wr_exact
         assign wr_frame = {OPC_PROG, addr, wdat};
      end else begin : g_wr_pad
         assign wr_frame = {OPC_PROG, addr, wdat, {(FB-40){1'b0}}};
      end
   endgenerate

   generate
      for (genvar i = 0; i < PGM_BYTES; i++) begin : g_pack
         assign pgm_frame[8*i +: 8] = pgm_flat[8*i +: 8];
      end
   endgenerate

   assign pgm_bits = (cnt > 8'(FB)) ? CNT_W'(FB) : cnt[CNT_W-1:0];

   always_comb begin
      frame = '0;
      nbits = '0;
      case (op)
         OP_STAT: begin frame = stat_frame; nbits = CNT_W'(16); end
         OP_PGM:  begin frame = pgm_frame;  nbits = pgm_bits;   end
         OP_WR:   begin frame = wr_frame;   nbits = CNT_W'(40); end
         default: ;
      endcase
   end
endmodule

// File: rtl/nor_shift_engine.sv
module nor_shift_engine
   import nor_cmd_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int FB      = 48,
   parameter int CNT_W   = $clog2(FB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [FB-1:0]    frame,
   input  logic [CNT_W-1:0] nbits,
   output logic             sclk,
   output logic             cs_n,
   output logic             mosi,
   input  logic             miso,
   output logic [7:0]       rx_byte,
   output logic             idle,
   output logic             done
);
   localparam int HALF = CLK_DIV / 2;
   localparam int TW   = $clog2(CLK_DIV);

   eng_st_e          st;
   logic [TW-1:0]    tick;
   logic [FB-1:0]    sh;
   logic [CNT_W-1:0] left;
   logic             half_hit;
   logic             gap_hit;

   generate
      if (HALF == 1) begin : g_fast
         assign half_hit = 1'b1;
      end else begin : g_div
         assign half_hit = (tick == TW'(HALF - 1));
      end
   endgenerate
   assign gap_hit = (tick == TW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENG_IDLE;
         tick    <= '0;
         sh      <= '0;
         left    <= '0;
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         rx_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ENG_IDLE: begin
               tick <= '0;
               if (start) begin
                  sh   <= frame;
                  left <= nbits;
                  cs_n <= 1'b0;
                  st   <= ENG_LEAD;
               end
            end
            ENG_LEAD, ENG_LO: begin
               if (half_hit) begin
                  tick    <= '0;
                  sclk    <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
                  st      <= ENG_HI;
               end else tick <= tick + 1'b1;
            end
            ENG_HI: begin
               if (half_hit) begin
                  tick <= '0;
                  sclk <= 1'b0;
                  left <= left - 1'b1;
                  if (left == CNT_W'(1)) st <= ENG_TAIL;
                  else begin
                     sh <= sh << 1;
                     st <= ENG_LO;
                  end
               end else tick <= tick + 1'b1;
            end
            ENG_TAIL: begin
               if (half_hit) begin
                  tick <= '0;
                  cs_n <= 1'b1;
                  st   <= ENG_GAP;
               end else tick <= tick + 1'b1;
            end
            ENG_GAP: begin
               if (gap_hit) begin
                  tick <= '0;
                  done <= 1'b1;
                  st   <= ENG_IDLE;
               end else tick <= tick + 1'b1;
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   assign mosi = cs_n ? 1'b0 : sh[FB-1];
   assign idle = (st == ENG_IDLE);

   // R8
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R8
   start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (cs_n && nbits != '0));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int CLK_DIV   = 4,
   parameter int PGM_BYTES = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [3:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int FB    = 8 * PGM_BYTES;
   localparam int CNT_W = $clog2(FB + 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (PGM_BYTES < 5 || PGM_BYTES > 8) begin : g_bad_pgm
         $error("PGM_BYTES must lie in 5..8");
      end
   endgenerate

   logic [7:0]             trig_q;
   op_e                    cur_op;
   op_e                    sel_op;
   logic                   skip_pgm;
   logic                   launch;
   logic                   cmd_accept;
   logic                   eng_idle;
   logic                   eng_done;
   logic [7:0]             rx_byte;
   logic [FB-1:0]          frame;
   logic [CNT_W-1:0]       nbits;
   logic [23:0]            addr_q;
   logic [7:0]             wdat_q;
   logic [7:0]             cnt_q;
   logic                   key_ok;
   logic [8*PGM_BYTES-1:0] pgm_flat;
   logic                   stat_load;
   logic                   addr_inc;

   always_comb begin
      sel_op = OP_NONE;
      if (trig_q[BIT_STAT])     sel_op = OP_STAT;
      else if (trig_q[BIT_PGM]) sel_op = OP_PGM;
      else if (trig_q[BIT_WR])  sel_op = OP_WR;
   end

   assign skip_pgm   = (sel_op == OP_PGM) && (cnt_q == 8'd0);
   assign launch     = (cur_op == OP_NONE) && eng_idle && (sel_op != OP_NONE) && !skip_pgm;
   assign cmd_accept = reg_wr && (reg_addr == OFF_CMD) && key_ok &&
                       ((trig_q & TRIG_MASK) == 8'd0);
   assign stat_load  = eng_done && (cur_op == OP_STAT);
   assign addr_inc   = eng_done && (cur_op == OP_WR) && trig_q[BIT_INC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         cur_op <= OP_NONE;
      end else if (cmd_accept) begin
         trig_q <= reg_wdata & KEEP_MASK;
      end else begin
         if (cur_op == OP_NONE && skip_pgm) trig_q[BIT_PGM] <= 1'b0;
         if (launch) cur_op <= sel_op;
         if (eng_done) begin
            cur_op <= OP_NONE;
            case (cur_op)
               OP_STAT: trig_q[BIT_STAT] <= 1'b0;
               OP_PGM:  trig_q[BIT_PGM]  <= 1'b0;
               OP_WR:   trig_q[BIT_WR]   <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   nor_reg_file #(.PGM_BYTES(PGM_BYTES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .acc_addr  (reg_addr),
      .wr_data   (reg_wdata),
      .cmd_val   (trig_q),
      .stat_load (stat_load),
      .stat_data (rx_byte),
      .addr_inc  (addr_inc),
      .rd_data   (reg_rdata),
      .addr_q    (addr_q),
      .wdat_q    (wdat_q),
      .cnt_q     (cnt_q),
      .key_ok    (key_ok),
      .pgm_flat  (pgm_flat)
   );

   nor_frame_builder #(.PGM_BYTES(PGM_BYTES), .FB(FB), .CNT_W(CNT_W)) u_build (
      .op       (sel_op),
      .addr     (addr_q),
      .wdat     (wdat_q),
      .cnt      (cnt_q),
      .pgm_flat (pgm_flat),
      .frame    (frame),
      .nbits    (nbits)
   );

   nor_shift_engine #(.CLK_DIV(CLK_DIV), .FB(FB), .CNT_W(CNT_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .frame   (frame),
      .nbits   (nbits),
      .sclk    (spi_sclk),
      .cs_n    (spi_cs_n),
      .mosi    (spi_mosi),
      .miso    (spi_miso),
      .rx_byte (rx_byte),
      .idle    (eng_idle),
      .done    (eng_done)
   );

   // R3
   active_has_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_op != OP_NONE) |-> ((trig_q & TRIG_MASK) != 8'd0));
   // R9
   no_new_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((trig_q & TRIG_MASK) != 8'd0) |=> ((trig_q & ~$past(trig_q) & TRIG_MASK) == 8'd0));
   // R2
   key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_CMD && !key_ok && (trig_q & TRIG_MASK) == 8'd0)
      |=> ((trig_q & TRIG_MASK) == 8'd0));
   // R8
   frame_only_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n) |-> (cur_op != OP_NONE));
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
   localparam int CLK_DIV = 4;
   localparam int PGM_BYTES = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic spi_sclk, spi_cs_n, spi_mosi;
   logic spi_miso = 1'b0;

   nor_cmd_seq #(.CLK_DIV(CLK_DIV), .PGM_BYTES(PGM_BYTES)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // flash model and bus monitor
   logic [7:0]  flash_status = 8'h00;
   logic [63:0] fb = '0;
   int nb = 0;
   int frames = 0;
   int gap = 100;
   int since_rise = 0;
   int gap_err = 0, per_err = 0, idle_err = 0;
   logic p_sclk = 1'b0, p_cs = 1'b1;
   logic [63:0] rec_bits [8];
   int rec_nb [8];

   always @(negedge clk) begin
      if (rst_n) begin
         since_rise++;
         if (spi_cs_n) begin
            gap++;
            if (spi_sclk) idle_err++;
         end
         if (p_cs && !spi_cs_n) begin
            if (frames > 0 && gap < CLK_DIV) gap_err++;
            nb = 0;
            fb = '0;
         end
         if (!p_sclk && spi_sclk && !spi_cs_n) begin
            if (nb > 0 && since_rise != CLK_DIV) per_err++;
            since_rise = 0;
            fb = {fb[62:0], spi_mosi};
            nb++;
         end
         if (p_sclk && !spi_sclk && !spi_cs_n)
            spi_miso = (nb >= 8 && nb < 16) ? flash_status[15-nb] : 1'b0;
         if (!p_cs && spi_cs_n) begin
            rec_bits[frames % 8] = fb;
            rec_nb[frames % 8] = nb;
            frames++;
            gap = 0;
            spi_miso = 1'b0;
         end
         p_sclk = spi_sclk;
         p_cs = spi_cs_n;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_done();
      logic [7:0] v;
      int n = 0;
      do begin
         rd(4'h0, v);
         n++;
      end while ((v & 8'h7f) != 0 && n < 20000);
      if (n >= 20000) chk("R3 completion timeout", 64'(v), 64'h0);
   endtask

   task automatic set_addr(input logic [23:0] a);
      wr(4'h3, a[7:0]); wr(4'h4, a[15:8]); wr(4'h5, a[23:16]);
   endtask

   task automatic get_addr(output logic [23:0] a);
      logic [7:0] b0, b1, b2;
      rd(4'h3, b0); rd(4'h4, b1); rd(4'h5, b2);
      a = {b2, b1, b0};
   endtask

   task automatic set_pgm(input logic [47:0] p);
      for (int i = 0; i < 6; i++) wr(4'(8 + i), p[8*i +: 8]);
   endtask

   function automatic logic [63:0] exp_wr(input logic [23:0] a, input logic [7:0] d);
      return {24'h0, 8'h02, a, d};
   endfunction

   function automatic logic [63:0] exp_pgm(input logic [47:0] p, input int n);
      return 64'(p >> (48 - n));
   endfunction

   function automatic int clamp_cnt(input int c);
      return (c > 48) ? 48 : c;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic [23:0] a;
      logic [47:0] p;
      int f0, n;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(4'h0, v); chk("R3 reset cmd", 64'(v), 64'h0);
      rd(4'h2, v); chk("R5 reset status", 64'(v), 64'h0);
      chk("R8 reset cs_n", 64'(spi_cs_n), 64'h1);
      chk("R8 reset sclk", 64'(spi_sclk), 64'h0);

      // R2: command before key
      f0 = frames;
      wr(4'h0, 8'h02);
      rd(4'h0, v); chk("R2 cmd without key", 64'(v), 64'h0);
      repeat (40) @(negedge clk);
      chk("R2 no frame without key", 64'(frames - f0), 64'h0);
      wr(4'h7, 8'h31); wr(4'h0, 8'h10);
      rd(4'h0, v); chk("R2 cmd with wrong key", 64'(v), 64'h0);
      wr(4'h7, 8'h30);

      // R1: unimplemented bits
      f0 = frames;
      wr(4'h0, 8'h69);
      rd(4'h0, v); chk("R1 unused bits read zero", 64'(v), 64'h0);
      repeat (40) @(negedge clk);
      chk("R1 unused bits start nothing", 64'(frames - f0), 64'h0);

      // R11: readback
      wr(4'h1, 8'h5a); rd(4'h1, v); chk("R11 count readback", 64'(v), 64'h5a);
      wr(4'h6, 8'hc3); rd(4'h6, v); chk("R11 wdata readback", 64'(v), 64'hc3);
      rd(4'h7, v); chk("R11 key readback", 64'(v), 64'h30);
      p = {$urandom, $urandom} & 48'hffff_ffff_ffff;
      set_pgm(p);
      for (int i = 0; i < 6; i++) begin
         rd(4'(8 + i), v); chk("R11 command byte readback", 64'(v), 64'(p[8*i +: 8]));
      end
      rd(4'he, v); chk("R11 unmapped 0xE", 64'(v), 64'h0);
      rd(4'hf, v); chk("R11 unmapped 0xF", 64'(v), 64'h0);
      a = 24'($urandom);
      set_addr(a);
      begin
         logic [23:0] ra;
         get_addr(ra); chk("R11 address readback", 64'(ra), 64'(a));
      end

      // R5: status reads with random values
      for (int i = 0; i < 4; i++) begin
         flash_status = 8'($urandom);
         if (i == 0) flash_status = 8'h81;
         f0 = frames;
         wr(4'h0, 8'h02);
         wait_done();
         chk("R5 one frame", 64'(frames - f0), 64'h1);
         chk("R5 frame bits", 64'(rec_nb[f0 % 8]), 64'd16);
         chk("R5 opcode out", rec_bits[f0 % 8], 64'h0500);
         rd(4'h2, v); chk("R5 status captured", 64'(v), 64'(flash_status));
      end

      // R4: write-enable and sector erase style frames
      p = 48'h06_0000_0000_00;
      set_pgm(p); wr(4'h1, 8'd8);
      f0 = frames; wr(4'h0, 8'h04); wait_done();
      chk("R4 8-bit frame length", 64'(rec_nb[f0 % 8]), 64'd8);
      chk("R4 8-bit frame content", rec_bits[f0 % 8], 64'h06);
      a = 24'($urandom);
      p = {8'h20, a, 16'h0};
      set_pgm(p); wr(4'h1, 8'd32);
      f0 = frames; wr(4'h0, 8'h04); wait_done();
      chk("R4 32-bit frame length", 64'(rec_nb[f0 % 8]), 64'd32);
      chk("R4 32-bit frame content", rec_bits[f0 % 8], {32'h0, 8'h20, a});

      // R4: random counts
      for (int i = 0; i < 5; i++) begin
         p = {$urandom, $urandom} & 48'hffff_ffff_ffff;
         n = 1 + int'($urandom % 48);
         set_pgm(p); wr(4'h1, 8'(n));
         f0 = frames; wr(4'h0, 8'h04); wait_done();
         chk("R4 random length", 64'(rec_nb[f0 % 8]), 64'(n));
         chk("R4 random content", rec_bits[f0 % 8], exp_pgm(p, n));
      end

      // R4: count clamp and zero count
      wr(4'h1, 8'd200);
      f0 = frames; wr(4'h0, 8'h04); wait_done();
      chk("R4 clamp length", 64'(rec_nb[f0 % 8]), 64'(clamp_cnt(200)));
      chk("R4 clamp content", rec_bits[f0 % 8], exp_pgm(p, 48));
      wr(4'h1, 8'd0);
      f0 = frames; wr(4'h0, 8'h04); wait_done();
      repeat (20) @(negedge clk);
      chk("R4 zero count sends nothing", 64'(frames - f0), 64'h0);

      // R6: byte program, no increment
      for (int i = 0; i < 3; i++) begin
         logic [23:0] ra;
         a = 24'($urandom);
         v = 8'($urandom);
         set_addr(a); wr(4'h6, v);
         f0 = frames; wr(4'h0, 8'h10); wait_done();
         chk("R6 program length", 64'(rec_nb[f0 % 8]), 64'd40);
         chk("R6 program content", rec_bits[f0 % 8], exp_wr(a, v));
         get_addr(ra); chk("R6 address unchanged", 64'(ra), 64'(a));
      end

      // R7: auto-increment over two writes and R3 bit7 persistence
      begin
         logic [23:0] ra;
         a = 24'h00_12fe;
         set_addr(a);
         wr(4'h6, 8'h11);
         f0 = frames; wr(4'h0, 8'h90); wait_done();
         rd(4'h0, v); chk("R3 bit7 persists", 64'(v), 64'h80);
         wr(4'h6, 8'h22);
         wr(4'h0, 8'h90); wait_done();
         chk("R7 first address", rec_bits[f0 % 8], exp_wr(a, 8'h11));
         chk("R7 second address", rec_bits[(f0 + 1) % 8], exp_wr(a + 24'd1, 8'h22));
         get_addr(ra); chk("R7 address after two", 64'(ra), 64'(a + 24'd2));
         set_addr(24'hff_ffff);
         wr(4'h0, 8'h90); wait_done();
         get_addr(ra); chk("R7 wrap to zero", 64'(ra), 64'h0);
         wr(4'h0, 8'h00);
         rd(4'h0, v); chk("R3 bit7 cleared by next command", 64'(v), 64'h0);
      end

      // R9: command while busy
      flash_status = 8'h3c;
      f0 = frames;
      wr(4'h0, 8'h02);
      wr(4'h0, 8'h10);
      rd(4'h0, v); chk("R9 busy write ignored", 64'(v), 64'h02);
      wait_done();
      repeat (40) @(negedge clk);
      chk("R9 only one frame", 64'(frames - f0), 64'h1);

      // R10: combined triggers
      flash_status = 8'ha5;
      p = 48'h9f_0000_0000_00;
      set_pgm(p); wr(4'h1, 8'd8);
      a = 24'h45_6789; set_addr(a); wr(4'h6, 8'h77);
      f0 = frames; wr(4'h0, 8'h16); wait_done();
      chk("R10 three frames", 64'(frames - f0), 64'h3);
      chk("R10 first is status", rec_bits[f0 % 8], 64'h0500);
      chk("R10 second is programmed", rec_bits[(f0 + 1) % 8], 64'h9f);
      chk("R10 third is byte program", rec_bits[(f0 + 2) % 8], exp_wr(a, 8'h77));
      rd(4'h2, v); chk("R10 status stored", 64'(v), 64'ha5);

      // R8: bus timing monitors
      chk("R8 sclk period", 64'(per_err), 64'h0);
      chk("R8 chip select gap", 64'(gap_err), 64'h0);
      chk("R8 sclk low while deselected", 64'(idle_err), 64'h0);

      finish_run();
   end
endmodule